// File: doc/BRIEF.md
# Bus Hold Request Controller

This block sits between a bus master's cycle-start logic and an outside agent that wants the bus. The agent pulls an active-low hold request. The controller then takes four steps in order. It stops granting new bus cycles. It waits for any cycle already in flight to finish. It spends one clock with the bus idle. Only then does it pull the active-low hold acknowledge. When the agent lets go of the request, the acknowledge goes high first. One clock later the start gate reopens.

A two-bit power mode changes how the handshake works. In the halted mode the acknowledge follows the request directly and skips the normal sequence. In the two clock-stopped modes a request is never honoured. If the agent withdraws its request before the acknowledge is given, the controller reopens the gate and never pulses the acknowledge.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `hold_ack_n`=1, `start_block`=0 and `start_gnt`=0.
- R2: `hold_req_n` is active low (0 = request) and passes through a two-stage synchronizer. In run mode (`pwr_mode`=00), holding it at 0 raises `start_block` on the third clock edge after the change, and not before.
- R3: `start_gnt` is a registered copy of `start_req`. It is forced to 0 in any cycle where `start_block` is 1.
- R4: While `cycle_busy` is 1 in run mode, `hold_ack_n` stays 1 no matter how long the request lasts.
- R5: Once `cycle_busy` is seen at 0 during the wait, the bus spends exactly one idle clock. `hold_ack_n` goes to 0 on the second edge after `cycle_busy` was sampled low, and `start_block` stays 1 throughout.
- R6: Once the release is seen by the synchronizer, `hold_ack_n` returns to 1 first. On the following edge `start_block` returns to 0 and `start_gnt` may follow `start_req` again.
- R7: If the request is withdrawn before the acknowledge is given, `start_block` returns to 0 and `hold_ack_n` stays at 1 in every cycle.
- R8: In halted mode (`pwr_mode`=01), `hold_ack_n` falls together with `start_block`, on the third edge after the request. Release gives `hold_ack_n`=1 on the third edge after the release and `start_block`=0 one edge later.
- R9: In idle mode (`pwr_mode`=10) or stop mode (`pwr_mode`=11), a request changes neither `hold_ack_n` nor `start_block`. If the mode later returns to run while the request is still held, `start_block` rises on the next edge and the normal sequence follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_req_n | input | 1 | Asynchronous hold request, active low |
| cycle_busy | input | 1 | A bus cycle is in progress |
| start_req | input | 1 | The bus engine asks to start a cycle |
| pwr_mode | input | 2 | 00 run, 01 halted, 10 idle, 11 stop |
| start_gnt | output | 1 | Cycle start permitted (registered) |
| start_block | output | 1 | New cycle starts are inhibited |
| hold_ack_n | output | 1 | Hold acknowledge, active low |

## Verification
The bench keeps `cycle_busy` high for several cycles after a request. A controller that acknowledged early would drop `hold_ack_n` while a cycle was still on the bus. The bench drops busy and then checks the exact cycle of the acknowledge. This catches a missing idle clock, an extra one, or a wrong synchronizer depth. It releases the request and checks that the gate reopens one clock after the acknowledge. A design that reopened both together would let a cycle start before the agent has left the bus. It also withdraws a request mid-wait, which catches a stray acknowledge pulse. It checks the halted shortcut. It sends requests in the clock-stopped modes and then wakes back to run mode. A design that latched or dropped the pending request there would show up in that last step.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL   = 3'd0,
    ST_INH_WAIT = 3'd1,
    ST_BUS_IDLE = 3'd2,
    ST_HOLD     = 3'd3,
    ST_RELEASE  = 3'd4
  } hold_state_e;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_HALT = 2'd1,
    PM_IDLE = 2'd2,
    PM_STOP = 2'd3
  } pwr_mode_e;

  function automatic logic clk_stopped(pwr_mode_e m);
    return (m == PM_IDLE) || (m == PM_STOP);
  endfunction

endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bhc_fsm.sv
module bhc_fsm
  import bhc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        cycle_busy,
  input  logic [1:0]  pwr_mode,
  output hold_state_e state_d
);
  hold_state_e state_q;
  pwr_mode_e   mode;

  assign mode = pwr_mode_e'(pwr_mode);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (req && !clk_stopped(mode))
          state_d = (mode == PM_HALT) ? ST_HOLD : ST_INH_WAIT;
      end
      ST_INH_WAIT: begin
        if (!req)             state_d = ST_NORMAL;
        else if (!cycle_busy) state_d = ST_BUS_IDLE;
      end
      ST_BUS_IDLE: state_d = req ? ST_HOLD : ST_NORMAL;
      ST_HOLD:     if (!req) state_d = ST_RELEASE;
      ST_RELEASE:  state_d = ST_NORMAL;
      default:     state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_NORMAL;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/bhc_outreg.sv
module bhc_outreg
  import bhc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  hold_state_e state_d,
  input  logic        start_req,
  output logic        hold_ack_n,
  output logic        start_block,
  output logic        start_gnt
);
  logic blk_d;

  assign blk_d = (state_d != ST_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_ack_n  <= 1'b1;
      start_block <= 1'b0;
      start_gnt   <= 1'b0;
    end else begin
      hold_ack_n  <= (state_d != ST_HOLD);
      start_block <= blk_d;
      start_gnt   <= start_req && !blk_d;
    end
  end
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bhc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold_req_n,
  input  logic       cycle_busy,
  input  logic       start_req,
  input  logic [1:0] pwr_mode,
  output logic       start_gnt,
  output logic       start_block,
  output logic       hold_ack_n
);
  logic        req_n_sync;
  logic        req;
  hold_state_e state_d;

  bhc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (hold_req_n),
    .q   (req_n_sync)
  );

  assign req = !req_n_sync;

  bhc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .cycle_busy (cycle_busy),
    .pwr_mode   (pwr_mode),
    .state_d    (state_d)
  );

  bhc_outreg u_out (
    .clk         (clk),
    .rst         (rst),
    .state_d     (state_d),
    .start_req   (start_req),
    .hold_ack_n  (hold_ack_n),
    .start_block (start_block),
    .start_gnt   (start_gnt)
  );
endmodule

// File: rtl/bus_hold_ctrl_chk.sv
module bus_hold_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cycle_busy,
  input logic [1:0] pwr_mode,
  input logic       start_gnt,
  input logic       start_block,
  input logic       hold_ack_n
);
  logic rst_seen = 1'b0;

  always_ff @(posedge clk) rst_seen <= rst;

  // R1: outputs after a reset edge
  always_ff @(posedge clk) begin
    if (rst_seen)
      a_r1_reset_state: assert (hold_ack_n && !start_block && !start_gnt);
  end

  a_r3_gnt_gated: assert property (@(posedge clk) disable iff (rst)
    start_gnt |-> !start_block);

  a_r5_ack_under_block: assert property (@(posedge clk) disable iff (rst)
    !hold_ack_n |-> start_block);

  a_r4_ack_after_idle: assert property (@(posedge clk) disable iff (rst)
    ($fell(hold_ack_n) && $past(pwr_mode) == 2'd0)
      |-> ($past(start_block) && !$past(cycle_busy, 2)));

  a_r6_ack_before_unblock: assert property (@(posedge clk) disable iff (rst)
    $fell(start_block) |-> $past(hold_ack_n));

  a_r9_no_entry_stopped: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode[1] && hold_ack_n && !start_block) |=> (hold_ack_n && !start_block));
endmodule

bind bus_hold_ctrl bus_hold_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cycle_busy  (cycle_busy),
  .pwr_mode    (pwr_mode),
  .start_gnt   (start_gnt),
  .start_block (start_block),
  .hold_ack_n  (hold_ack_n)
);

// File: tb/sim_bus_hold_ctrl.sv
module sim_bus_hold_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold_req_n = 1'b1;
  logic       cycle_busy = 1'b0;
  logic       start_req  = 1'b0;
  logic [1:0] pwr_mode   = 2'd0;
  logic       start_gnt, start_block, hold_ack_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int    at;
    logic  ack_n;
    logic  blk;
    logic  gnt;
    string tag;
  } exp_t;

  exp_t sb[$];

  bus_hold_ctrl u0 (
    .clk         (clk),
    .rst         (rst),
    .hold_req_n  (hold_req_n),
    .cycle_busy  (cycle_busy),
    .start_req   (start_req),
    .pwr_mode    (pwr_mode),
    .start_gnt   (start_gnt),
    .start_block (start_block),
    .hold_ack_n  (hold_ack_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // driver side: expectation n edges from now, grant follows start_req unless blocked
  task automatic expect_in(input int n, input logic ack_n, input logic blk, input string tag);
    exp_t e;
    e.at = cyc + n; e.ack_n = ack_n; e.blk = blk;
    e.gnt = start_req && !blk; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor side
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (hold_ack_n !== e.ack_n || start_block !== e.blk || start_gnt !== e.gnt) begin
        fails++;
        $display("FAIL %s cyc=%0d actual ack_n=%b blk=%b gnt=%b expected ack_n=%b blk=%b gnt=%b",
                 e.tag, cyc, hold_ack_n, start_block, start_gnt, e.ack_n, e.blk, e.gnt);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    expect_in(0, 1'b1, 1'b0, "R1");
    tick(2);

    // R3: grant follows request when not blocked
    start_req = 1'b1;
    expect_in(1, 1'b1, 1'b0, "R3");
    tick(2);
    start_req = 1'b0;
    expect_in(1, 1'b1, 1'b0, "R3");
    tick(2);
    start_req = 1'b1;
    tick(2);

    // R2/R4: request while a cycle is in flight
    cycle_busy = 1'b1;
    tick(1);
    hold_req_n = 1'b0;
    expect_in(2, 1'b1, 1'b0, "R2");
    expect_in(3, 1'b1, 1'b1, "R2");
    expect_in(4, 1'b1, 1'b1, "R3");
    expect_in(6, 1'b1, 1'b1, "R4");
    expect_in(8, 1'b1, 1'b1, "R4");
    tick(8);
    // R5: one idle clock then acknowledge
    cycle_busy = 1'b0;
    expect_in(1, 1'b1, 1'b1, "R5");
    expect_in(2, 1'b0, 1'b1, "R5");
    expect_in(4, 1'b0, 1'b1, "R5");
    tick(4);
    // R6: release ordering
    hold_req_n = 1'b1;
    expect_in(2, 1'b0, 1'b1, "R6");
    expect_in(3, 1'b1, 1'b1, "R6");
    expect_in(4, 1'b1, 1'b0, "R6");
    tick(6);

    // R5: request with the bus already quiet
    hold_req_n = 1'b0;
    expect_in(3, 1'b1, 1'b1, "R5");
    expect_in(4, 1'b1, 1'b1, "R5");
    expect_in(5, 1'b0, 1'b1, "R5");
    tick(6);
    hold_req_n = 1'b1;
    expect_in(5, 1'b1, 1'b0, "R6");
    tick(6);

    // R7: withdraw before acknowledge
    cycle_busy = 1'b1;
    hold_req_n = 1'b0;
    tick(3);
    hold_req_n = 1'b1;
    expect_in(0, 1'b1, 1'b1, "R7");
    expect_in(1, 1'b1, 1'b1, "R7");
    expect_in(2, 1'b1, 1'b1, "R7");
    expect_in(3, 1'b1, 1'b0, "R7");
    expect_in(5, 1'b1, 1'b0, "R7");
    tick(5);
    cycle_busy = 1'b0;
    tick(2);

    // R8: halted mode shortcut
    pwr_mode = 2'd1;
    tick(1);
    hold_req_n = 1'b0;
    expect_in(2, 1'b1, 1'b0, "R8");
    expect_in(3, 1'b0, 1'b1, "R8");
    tick(4);
    hold_req_n = 1'b1;
    expect_in(2, 1'b0, 1'b1, "R8");
    expect_in(3, 1'b1, 1'b1, "R8");
    expect_in(4, 1'b1, 1'b0, "R8");
    tick(5);
    pwr_mode = 2'd0;
    tick(1);

    // R9: clock-stopped modes never enter hold
    pwr_mode = 2'd2;
    tick(1);
    hold_req_n = 1'b0;
    for (int i = 3; i <= 6; i++) expect_in(i, 1'b1, 1'b0, "R9");
    tick(7);
    pwr_mode = 2'd3;
    for (int i = 1; i <= 3; i++) expect_in(i, 1'b1, 1'b0, "R9");
    tick(4);
    pwr_mode = 2'd0;
    expect_in(1, 1'b1, 1'b1, "R9");
    expect_in(3, 1'b0, 1'b1, "R9");
    tick(4);
    hold_req_n = 1'b1;
    expect_in(4, 1'b1, 1'b0, "R6");
    tick(6);

    if (sb.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard actual pending=%0d expected pending=0", sb.size());
    end
    finish_run();
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual cycles=%0d expected done earlier", WATCHDOG);
    finish_run();
  end
endmodule